// File: doc/BRIEF.md
# LFSR Stream Message Encryptor

The block turns a short ASCII message into a 64-byte encrypted frame. Software or an upstream agent first writes the message characters into an internal store through a simple write port. It then pulses `start` with four settings: a tap-pattern index, a seed, a preamble length and a message length. From these the block builds a frame. The frame begins with a run of space characters, then holds the message, then space characters up to byte 63. Each frame byte has 0x20 subtracted from it and is then XORed with the state of a 7-bit maximal-length linear feedback shift register.

The encrypted bytes leave one at a time on a valid/ready stream. The register advances once for every byte the consumer accepts. Once the last byte has been taken, the block raises a one-cycle `done` pulse and goes idle, ready for the next message.

Top module: `lfsr_msg_cipher`

## Requirements
- R1: After reset is released, `out_valid` and `done` are both 0 and stay 0 until a frame is started.
- R2: The register state used for frame byte 0 is the seed latched at start. A seed of 0 is replaced by 1, so the state is never all zeros.
- R3: The tap pattern is picked by `pat_sel` from this table: 0→0x60, 1→0x48, 2→0x78, 3→0x72, 4→0x6A, 5→0x69, 6→0x5C, 7→0x7E, 8→0x7B. An index from 9 to 15 is folded back into range by clearing its bit 3.
- R4: For byte k, `out_data` = (frame character − 0x20) XOR {0, state_k}. The next state is the state shifted left one place, with the parity of (state AND taps) placed in bit 0.
- R5: The frame is 64 bytes long. Positions 0 to P−1 hold space (0x20). Positions P to P+L−1 hold message characters 0 to L−1. All later positions hold space. Message characters that would land beyond position 63 are dropped.
- R6: The preamble length P is the `pre_len` latched at start, clamped to the range 10 to 26.
- R7: The message length L is the `msg_len` latched at start, limited to at most 54.
- R8: A stored character below 0x20 is treated as 0x20, and one above 0x9F is treated as 0x9F. As a result, bit 7 of every output byte is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value. A byte is consumed on a clock edge where both are 1.
- R10: `done` is 1 for exactly the one cycle after byte 63 is accepted. `out_valid` is 0 in that cycle.
- R11: While a frame is in progress, `start` has no effect and message writes are discarded.
- R12: When idle, `msg_wr` stores `msg_data` as message character number `msg_addr` (0-based, valid up to 53).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| pat_sel | input | 4 | Tap-pattern index |
| seed | input | 7 | Initial register state |
| pre_len | input | 8 | Requested count of leading spaces |
| msg_len | input | 8 | Requested message length |
| msg_wr | input | 1 | Message character write strobe |
| msg_addr | input | 6 | Message character index |
| msg_data | input | 8 | Message character value |
| out_valid | output | 1 | Encrypted byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Encrypted byte |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The bench targets the clamping edges:
- A zero seed would give an all-zero keystream if it were not replaced.
- A preamble of 3 or 200 would shift every message character if the clamp were missing.
- A length of 60 would read past the store.
- Characters of 0x05 and 0xF0 would set output bit 7 or wrap after the offset.

Tap indices 9 to 15 check the fold. A wrong fold picks the wrong pattern, and the keystream then diverges from byte 1 onward.

Random back-pressure checks that bytes are neither dropped nor repeated and that the register does not advance during a stall. A `start` pulse and a message write injected in the middle of a frame must leave every later byte unchanged. The `done` pulse is checked for its width and for its position after byte 63.

// File: rtl/cipher_pkg.sv
package cipher_pkg;

  // Tap pattern lookup; index above 8 has bit 3 cleared first.
  function automatic logic [7:0] tap_lookup(input logic [3:0] idx);
    logic [3:0] f;
    f = idx;
    if (f > 4'd8) f[3] = 1'b0;
    case (f)
      4'd0:    tap_lookup = 8'h60;
      4'd1:    tap_lookup = 8'h48;
      4'd2:    tap_lookup = 8'h78;
      4'd3:    tap_lookup = 8'h72;
      4'd4:    tap_lookup = 8'h6A;
      4'd5:    tap_lookup = 8'h69;
      4'd6:    tap_lookup = 8'h5C;
      4'd7:    tap_lookup = 8'h7E;
      default: tap_lookup = 8'h7B;
    endcase
  endfunction

endpackage

// File: rtl/lfsr_keystream.sv
module lfsr_keystream
  import cipher_pkg::*;
#(
  parameter int LFSR_W = 7,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [LFSR_W-1:0] seed,
  input  logic [SEL_W-1:0]  pat_sel,
  output logic [LFSR_W-1:0] state
);

  localparam logic [LFSR_W-1:0] ONE = LFSR_W'(1);

  logic [LFSR_W-1:0] state_q, state_d;
  logic [LFSR_W-1:0] taps_q, taps_d;
  logic [LFSR_W-1:0] seed_fix;
  logic [LFSR_W-1:0] step;
  logic              fb;
  logic [7:0]        tap_full;

  always_comb begin
    tap_full = tap_lookup(4'(pat_sel));
    seed_fix = (seed == '0) ? ONE : seed;
    fb       = ^(state_q & taps_q);
    step     = {state_q[LFSR_W-2:0], fb};
    state_d  = state_q;
    taps_d   = taps_q;
    if (load) begin
      state_d = seed_fix;
      taps_d  = tap_full[LFSR_W-1:0];
    end else if (adv) begin
      state_d = step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ONE;
      taps_q  <= '0;
    end else begin
      state_q <= state_d;
      taps_q  <= taps_d;
    end
  end

  assign state = state_q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R4
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(state_q));

endmodule

// File: rtl/msg_frame_buf.sv
module msg_frame_buf #(
  parameter int CHAR_W    = 8,
  parameter int LEN_W     = 8,
  parameter int MSG_MAX   = 54,
  parameter int FRAME_LEN = 64,
  parameter int PRE_MIN   = 10,
  parameter int PRE_MAX   = 26,
  parameter int AW        = $clog2(MSG_MAX),
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              lock,
  input  logic              cfg_load,
  input  logic [LEN_W-1:0]  pre_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [IDX_W-1:0]  pos,
  output logic [CHAR_W-1:0] frame_char
);

  localparam logic [CHAR_W-1:0] SPACE    = CHAR_W'(8'h20);
  localparam logic [CHAR_W-1:0] CHAR_TOP = CHAR_W'(8'h9F);
  localparam logic [LEN_W-1:0]  PRE_LO   = LEN_W'(PRE_MIN);
  localparam logic [LEN_W-1:0]  PRE_HI   = LEN_W'(PRE_MAX);
  localparam logic [LEN_W-1:0]  LEN_HI   = LEN_W'(MSG_MAX);

  logic [MSG_MAX-1:0][CHAR_W-1:0] ent_bus;
  logic [CHAR_W-1:0] wr_clamped;
  logic [LEN_W-1:0]  pre_q, pre_d, len_q, len_d;
  logic [LEN_W:0]    pos_x, rel;
  logic [AW-1:0]     rel_idx;
  logic              in_msg;
  logic [CHAR_W-1:0] raw_char;

  always_comb begin
    if (wr_data < SPACE)         wr_clamped = SPACE;
    else if (wr_data > CHAR_TOP) wr_clamped = CHAR_TOP;
    else                         wr_clamped = wr_data;
  end

  for (genvar g = 0; g < MSG_MAX; g++) begin : g_ent
    logic              we;
    logic [CHAR_W-1:0] ent_q;
    assign we = wr_en && !lock && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q <= SPACE;
      else if (we) ent_q <= wr_clamped;
    end
    assign ent_bus[g] = ent_q;
  end

  always_comb begin
    pre_d = pre_q;
    len_d = len_q;
    if (cfg_load) begin
      if (pre_in < PRE_LO)      pre_d = PRE_LO;
      else if (pre_in > PRE_HI) pre_d = PRE_HI;
      else                      pre_d = pre_in;
      len_d = (len_in > LEN_HI) ? LEN_HI : len_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_LO;
      len_q <= '0;
    end else begin
      pre_q <= pre_d;
      len_q <= len_d;
    end
  end

  always_comb begin
    pos_x   = (LEN_W+1)'(pos);
    rel     = pos_x - {1'b0, pre_q};
    in_msg  = (pos_x >= {1'b0, pre_q}) && (rel < {1'b0, len_q});
    rel_idx = rel[AW-1:0];
    raw_char = SPACE;
    if (in_msg && (rel_idx < AW'(MSG_MAX))) raw_char = ent_bus[rel_idx];
    frame_char = raw_char - SPACE;
  end

  // R8
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_char[CHAR_W-1] == 1'b0);

  // R6
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q >= PRE_LO) && (pre_q <= PRE_HI));

  // R7
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LEN_HI);

endmodule

// File: rtl/cipher_ctrl.sv
module cipher_ctrl #(
  parameter int FRAME_LEN = 64,
  parameter int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             done,
  output logic             busy,
  output logic             cfg_load,
  output logic             adv,
  output logic [IDX_W-1:0] pos
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic             run_q, run_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] pos_q, pos_d;
  logic             accept, last_acc;

  always_comb begin
    cfg_load = start && !run_q;
    accept   = run_q && out_ready;
    last_acc = accept && (pos_q == LAST);
    run_d    = run_q;
    pos_d    = pos_q;
    done_d   = last_acc;
    if (cfg_load) begin
      run_d = 1'b1;
      pos_d = '0;
    end else if (accept) begin
      if (last_acc) run_d = 1'b0;
      else          pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      pos_q  <= pos_d;
      done_q <= done_d;
    end
  end

  assign out_valid = run_q;
  assign busy      = run_q;
  assign done      = done_q;
  assign adv       = accept;
  assign pos       = pos_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (pos_q == LAST)) |=> (done && !out_valid));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !out_ready) |=> $stable(pos_q));

endmodule

// File: rtl/lfsr_msg_cipher.sv
module lfsr_msg_cipher #(
  parameter int LFSR_W    = 7,
  parameter int SEL_W     = 4,
  parameter int CHAR_W    = 8,
  parameter int LEN_W     = 8,
  parameter int FRAME_LEN = 64,
  parameter int MSG_MAX   = 54,
  parameter int PRE_MIN   = 10,
  parameter int PRE_MAX   = 26,
  parameter int MSG_AW    = $clog2(MSG_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  pat_sel,
  input  logic [LFSR_W-1:0] seed,
  input  logic [LEN_W-1:0]  pre_len,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic              msg_wr,
  input  logic [MSG_AW-1:0] msg_addr,
  input  logic [CHAR_W-1:0] msg_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  output logic              done
);

  localparam int IDX_W = $clog2(FRAME_LEN);

  logic              busy, cfg_load, adv;
  logic [IDX_W-1:0]  pos;
  logic [LFSR_W-1:0] ks_state;
  logic [CHAR_W-1:0] frame_char;

  cipher_ctrl #(.FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .out_valid(out_valid), .done(done), .busy(busy),
    .cfg_load(cfg_load), .adv(adv), .pos(pos)
  );

  lfsr_keystream #(.LFSR_W(LFSR_W), .SEL_W(SEL_W)) u_ks (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .adv(adv),
    .seed(seed), .pat_sel(pat_sel), .state(ks_state)
  );

  msg_frame_buf #(
    .CHAR_W(CHAR_W), .LEN_W(LEN_W), .MSG_MAX(MSG_MAX), .FRAME_LEN(FRAME_LEN),
    .PRE_MIN(PRE_MIN), .PRE_MAX(PRE_MAX), .AW(MSG_AW), .IDX_W(IDX_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(msg_wr), .wr_addr(msg_addr),
    .wr_data(msg_data), .lock(busy), .cfg_load(cfg_load),
    .pre_in(pre_len), .len_in(msg_len), .pos(pos), .frame_char(frame_char)
  );

  assign out_data = frame_char ^ CHAR_W'(ks_state);

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  out_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[CHAR_W-1] == 1'b0));

endmodule

// File: tb/lfsr_msg_cipher_bench.sv
module lfsr_msg_cipher_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] pat_sel = '0;
  logic [6:0] seed = '0;
  logic [7:0] pre_len = '0;
  logic [7:0] msg_len = '0;
  logic       msg_wr = 1'b0;
  logic [5:0] msg_addr = '0;
  logic [7:0] msg_data = '0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       done;

  int checks = 0;
  int errors = 0;
  logic [7:0] msg_ref [54];
  logic [7:0] exp_q [64];

  always #4ns clk = ~clk;

  lfsr_msg_cipher u_lfsr_msg_cipher (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_sel(pat_sel), .seed(seed),
    .pre_len(pre_len), .msg_len(msg_len), .msg_wr(msg_wr), .msg_addr(msg_addr),
    .msg_data(msg_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [6:0] tap_of(input int sel);
    int f;
    f = sel;
    if (f > 8) f = f - 8;
    case (f)
      0: tap_of = 7'h60; 1: tap_of = 7'h48; 2: tap_of = 7'h78;
      3: tap_of = 7'h72; 4: tap_of = 7'h6A; 5: tap_of = 7'h69;
      6: tap_of = 7'h5C; 7: tap_of = 7'h7E; default: tap_of = 7'h7B;
    endcase
  endfunction

  task automatic build(input int sel, input int sd, input int pre, input int len);
    logic [6:0] s, t;
    logic [7:0] c;
    int p, l;
    s = (sd[6:0] == 0) ? 7'd1 : sd[6:0];
    t = tap_of(sel);
    p = (pre < 10) ? 10 : ((pre > 26) ? 26 : pre);
    l = (len > 54) ? 54 : len;
    for (int pos = 0; pos < 64; pos++) begin
      c = 8'h20;
      if (pos >= p && (pos - p) < l) begin
        c = msg_ref[pos - p];
        if (c < 8'h20) c = 8'h20;
        if (c > 8'h9F) c = 8'h9F;
      end
      exp_q[pos] = (c - 8'h20) ^ {1'b0, s};
      s = {s[5:0], ^(s & t)};
    end
  endtask

  // mode 0 random, 1 in range, 2 out-of-range alternating
  task automatic load_msg(input int mode);
    for (int i = 0; i < 54; i++) begin
      @(negedge clk);
      msg_wr = 1'b1;
      msg_addr = 6'(i);
      case (mode)
        1: msg_data = 8'h21 + 8'(i);
        2: msg_data = i[0] ? 8'hF0 : 8'h05;
        default: msg_data = 8'($urandom);
      endcase
      msg_ref[i] = msg_data;
    end
    @(negedge clk);
    msg_wr = 1'b0;
  endtask

  task automatic launch(input int sel, input int sd, input int pre, input int len);
    build(sel, sd, pre, len);
    @(negedge clk);
    pat_sel = 4'(sel); seed = 7'(sd); pre_len = 8'(pre); msg_len = 8'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_frame(input int stall, input bit inject, input string tag);
    int k;
    bit rdy, injected;
    k = 0;
    injected = 1'b0;
    while (k < 64) begin
      chk(out_valid == 1'b1, "R9", out_valid, 1);
      chk(out_data == exp_q[k], tag, out_data, exp_q[k]);
      chk(done == 1'b0, "R10", done, 0);
      rdy = (($urandom % 100) >= stall);
      if (inject && k == 10 && !injected) begin
        injected = 1'b1;
        start = 1'b1; seed = 7'h55; pre_len = 8'd20; pat_sel = 4'd3;
        msg_wr = 1'b1; msg_addr = 6'd20; msg_data = 8'h7A;
      end
      out_ready = rdy;
      @(negedge clk);
      start = 1'b0;
      msg_wr = 1'b0;
      if (rdy) k++;
    end
    out_ready = 1'b0;
    chk(done == 1'b1, "R10", done, 1);
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", done, 0);
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(done == 1'b0, "R1", done, 0);

    // R2 zero seed, R12 write port, R5 layout
    load_msg(1);
    launch(0, 0, 10, 54);
    run_frame(0, 1'b0, "R2");

    // R3 folded index, R6 short preamble, R7 long message
    launch(12, 77, 3, 60);
    run_frame(30, 1'b0, "R3");

    // R6 long preamble, R8 out-of-range characters, R5 truncation at frame end
    load_msg(2);
    launch(8, 5, 200, 54);
    run_frame(20, 1'b0, "R8");

    // R11 start and write ignored mid-frame, R9 heavy stalls
    load_msg(1);
    launch(5, 99, 12, 54);
    run_frame(50, 1'b1, "R11");

    // R4 random configurations
    for (int n = 0; n < 12; n++) begin
      load_msg(0);
      launch(int'($urandom % 16), int'($urandom % 128),
             int'($urandom % 41), int'($urandom % 71));
      run_frame(30, 1'b0, "R4");
    end

    finish_up();
  end

endmodule